// File: doc/BRIEF.md
# Monochrome Composite Video Timing Generator

This block produces the timing for a black/white composite raster and streams a 1-bit image out of a word-wide frame buffer. A horizontal position counter wraps once per line period and a line counter wraps once per frame. A line-kind state machine, updated at each line wrap, sorts the lines into vertical-sync, blanking and picture lines. It picks the width of the sync pulse for each line. Both edges of every pulse come from compares on the position counter, so pulse timing never depends on how fast the control logic reacts.

On picture lines a second compare point, placed at the end of the back porch, opens the pixel window. The block fetches each line's words from the frame buffer through a synchronous read port with one cycle of latency. A shift register sends the bits out most significant bit first, holding each pixel for a power-of-two number of clocks. Outside the window the video bit is held dark. A one-clock frame marker flags the first cycle of every frame. Analog mixing, levels, interlace, colour and drawing into the buffer are left to other blocks.

Top module: `vid_timing_gen`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `syncN` is 1, `videoOut` is 0, `frameStart` is 0 and `rdEn` is 0. The first clock cycle after the first rising edge with `rst` low is cycle 0 of line 0.
- R2: Every line lasts `LINE_CYCLES` clock cycles, so consecutive falling edges of `syncN` are exactly `LINE_CYCLES` cycles apart, and a frame has `LINES_PER_FRAME` lines.
- R3: On every line numbered `VSYNC_LINES` or higher, `syncN` is 0 in cycles 0 to `HSYNC_CYCLES`-1 of the line and 1 for the rest of the line.
- R4: On lines 0 to `VSYNC_LINES`-1, `syncN` is 0 in cycles 0 to `VSYNC_CYCLES`-1 of the line and 1 for the rest of the line.
- R5: `frameStart` is 1 for exactly one cycle per frame, in cycle 0 of line 0.
- R6: On picture lines (`ACTIVE_FIRST` up to `ACTIVE_FIRST`+`ACTIVE_LINES`-1), the pixel window covers cycles `BURST_START` to `BURST_START`+2^(`PIX_LOG2`+`DIV_LOG2`)-1. Pixel i of the line is shown for the 2^`DIV_LOG2` cycles starting at `BURST_START`+i*2^`DIV_LOG2`.
- R7: Pixel i of picture row r (row = line - `ACTIVE_FIRST`) is bit 2^`WORD_LOG2`-1-(i mod 2^`WORD_LOG2`) of the buffer word at address r*2^(`PIX_LOG2`-`WORD_LOG2`) + i div 2^`WORD_LOG2`, so the most significant bit of each word is shown first. A bit value of 1 drives `videoOut` high.
- R8: `videoOut` is 0 in every cycle outside the pixel window, and in every cycle of sync and blanking lines.
- R9: On each picture line, `rdEn` is 1 for one cycle per word, in cycle `BURST_START`-3+k*2^(`WORD_LOG2`+`DIV_LOG2`) for word k. `rdAddr` carries that word's address from R7 in the same cycle. The word is expected on `rdData` in the next cycle. `rdEn` is never 1 on other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | output | 1 | Frame buffer read request |
| rdAddr | output | ADDR_W | Frame buffer word address (row, word) |
| rdData | input | 2^WORD_LOG2 | Word returned one cycle after the request |
| syncN | output | 1 | Sync level, 0 during a sync pulse |
| videoOut | output | 1 | Pixel level, 1 = white |
| frameStart | output | 1 | One-cycle marker at the first cycle of a frame |

## Verification
The assertions assume the buffer returns the requested word on `rdData` in exactly the cycle after `rdEn`. They also assume the parameters keep `BURST_START` at 3 or more, keep the pixel window inside the line, and make the long vertical pulse wider than the horizontal pulse plus one. The bench memory model answers every request with exactly one cycle of latency. It changes its content pattern only when a new frame begins, during the sync lines when no fetch can be in flight. The bench parameter set keeps every one of the relations above.

// File: rtl/vid_timing_pkg.sv
`timescale 1ns/1ps
package vid_timing_pkg;

  // Kind of the current raster line, chosen once per line at the wrap.
  typedef enum logic [1:0] {
    KIND_VSYNC  = 2'd0,
    KIND_BLANK  = 2'd1,
    KIND_ACTIVE = 2'd2
  } lineKind_t;

  // Strobes from the line control to the pixel datapath.
  typedef struct packed {
    logic fetch;   // read request for one buffer word
    logic load;    // returned word goes into the shifter
    logic shift;   // last clock of a pixel, advance to the next bit
    logic window;  // current cycle lies inside the pixel window
  } pixStrobe_t;

endpackage

// File: rtl/vid_line_ctrl.sv
`timescale 1ns/1ps
module vid_line_ctrl
  import vid_timing_pkg::*;
#(
  parameter int LINE_CYCLES     = 1905,
  parameter int HSYNC_CYCLES    = 141,
  parameter int VSYNC_CYCLES    = 1764,
  parameter int BURST_START     = 150,
  parameter int LINES_PER_FRAME = 262,
  parameter int VSYNC_LINES     = 3,
  parameter int ACTIVE_FIRST    = 40,
  parameter int ACTIVE_LINES    = 200,
  parameter int PIX_LOG2        = 8,
  parameter int WORD_LOG2       = 5,
  parameter int DIV_LOG2        = 2,
  localparam int ROW_W          = $clog2(ACTIVE_LINES),
  localparam int WORDS_LOG2     = PIX_LOG2 - WORD_LOG2,
  localparam int ADDR_W         = ROW_W + WORDS_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  output pixStrobe_t        strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              syncN,
  output logic              frameStart
);

  localparam int HPOS_W     = $clog2(LINE_CYCLES + 1);
  localparam int LINE_W     = $clog2(LINES_PER_FRAME);
  localparam int WC_LOG2    = WORD_LOG2 + DIV_LOG2;
  localparam int WORDS      = 1 << WORDS_LOG2;
  localparam int WORD_CYC   = 1 << WC_LOG2;
  localparam int WINDOW_CYC = (1 << PIX_LOG2) << DIV_LOG2;

  localparam logic [HPOS_W-1:0] LAST_POS    = HPOS_W'(LINE_CYCLES - 1);
  localparam logic [HPOS_W-1:0] HS_WIDTH    = HPOS_W'(HSYNC_CYCLES);
  localparam logic [HPOS_W-1:0] VS_WIDTH    = HPOS_W'(VSYNC_CYCLES);
  localparam logic [HPOS_W-1:0] FETCH_FIRST = HPOS_W'(BURST_START - 2);
  localparam logic [HPOS_W-1:0] FETCH_END   = HPOS_W'(BURST_START - 2 + WORDS * WORD_CYC);
  localparam logic [HPOS_W-1:0] WIN_FIRST   = HPOS_W'(BURST_START);
  localparam logic [HPOS_W-1:0] WIN_END     = HPOS_W'(BURST_START + WINDOW_CYC);
  localparam logic [HPOS_W-1:0] WC_MASK     = HPOS_W'(WORD_CYC - 1);
  localparam logic [HPOS_W-1:0] DIV_MASK    = HPOS_W'((1 << DIV_LOG2) - 1);
  localparam logic [LINE_W-1:0] LAST_LINE   = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [ROW_W-1:0]  LAST_ROW    = ROW_W'(ACTIVE_LINES - 1);

  function automatic lineKind_t kindOf(input logic [LINE_W-1:0] n);
    if (int'(n) < VSYNC_LINES)
      return KIND_VSYNC;
    else if (int'(n) >= ACTIVE_FIRST && int'(n) < ACTIVE_FIRST + ACTIVE_LINES)
      return KIND_ACTIVE;
    else
      return KIND_BLANK;
  endfunction

  logic [HPOS_W-1:0] hPos;
  logic [LINE_W-1:0] lineNo;
  logic [LINE_W-1:0] nextLine;
  logic [ROW_W-1:0]  rowIdx;
  lineKind_t         kind;
  logic [HPOS_W-1:0] pulseW;

  // Line-kind state machine: the pulse width is picked by the state,
  // while both pulse edges come from compares on hPos.
  always_comb begin
    nextLine = (lineNo == LAST_LINE) ? '0 : lineNo + LINE_W'(1);
    pulseW   = (kind == KIND_VSYNC) ? VS_WIDTH : HS_WIDTH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hPos       <= '0;
      lineNo     <= '0;
      rowIdx     <= '0;
      kind       <= kindOf('0);
      syncN      <= 1'b1;
      frameStart <= 1'b0;
    end else begin
      syncN      <= (hPos >= pulseW);
      frameStart <= (hPos == '0) && (lineNo == '0);
      if (hPos == LAST_POS) begin
        hPos   <= '0;
        lineNo <= nextLine;
        kind   <= kindOf(nextLine);
        if (kind == KIND_ACTIVE)
          rowIdx <= (rowIdx == LAST_ROW) ? '0 : rowIdx + ROW_W'(1);
      end else begin
        hPos <= hPos + HPOS_W'(1);
      end
    end
  end

  // Burst compare points: fetches lead the window by two counter steps.
  logic                  isActive;
  logic                  inFetch;
  logic                  inWin;
  logic [HPOS_W-1:0]     fetchOff;
  logic [HPOS_W-1:0]     pixOff;
  logic [WORDS_LOG2-1:0] wordIdx;

  always_comb begin
    isActive = (kind == KIND_ACTIVE);
    fetchOff = hPos - FETCH_FIRST;
    pixOff   = hPos - WIN_FIRST;
    inFetch  = isActive && (hPos >= FETCH_FIRST) && (hPos < FETCH_END);
    inWin    = isActive && (hPos >= WIN_FIRST) && (hPos < WIN_END);
    wordIdx  = WORDS_LOG2'(fetchOff >> WC_LOG2);

    strobe.fetch  = inFetch && ((fetchOff & WC_MASK) == '0);
    strobe.load   = inFetch && ((fetchOff & WC_MASK) == HPOS_W'(1));
    strobe.shift  = inWin && ((pixOff & DIV_MASK) == DIV_MASK);
    strobe.window = inWin;

    rdAddr = {rowIdx, wordIdx};
  end

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hPos == LAST_POS) |=> (hPos == '0));

  // R3
  hsync_end_chk: assert property (@(posedge clk) disable iff (rst)
    (kind != KIND_VSYNC && hPos == HS_WIDTH) |=> syncN);

  // R4
  vsync_long_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_VSYNC && hPos == HS_WIDTH) |=> !syncN);

  // R5
  frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  // R9
  fetch_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.fetch |=> !strobe.fetch);

endmodule

// File: rtl/vid_pixel_path.sv
`timescale 1ns/1ps
module vid_pixel_path
  import vid_timing_pkg::*;
#(
  parameter int WORD_LOG2 = 5,
  localparam int WORD_BITS = 1 << WORD_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pixStrobe_t           strobe,
  input  logic [WORD_BITS-1:0] rdData,
  output logic                 videoOut
);

  logic [WORD_BITS-1:0] shifter;

  // A fresh word wins over the shift of the previous word's last pixel.
  always_ff @(posedge clk) begin
    if (rst) begin
      shifter  <= '0;
      videoOut <= 1'b0;
    end else begin
      videoOut <= strobe.window & shifter[WORD_BITS-1];
      if (strobe.load)
        shifter <= rdData;
      else if (strobe.shift)
        shifter <= {shifter[WORD_BITS-2:0], 1'b0};
    end
  end

  // R8
  dark_outside_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.window |=> !videoOut);

  // R7
  word_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (shifter == $past(rdData)));

endmodule

// File: rtl/vid_timing_gen.sv
`timescale 1ns/1ps
module vid_timing_gen
  import vid_timing_pkg::*;
#(
  parameter int LINE_CYCLES     = 1905,
  parameter int HSYNC_CYCLES    = 141,
  parameter int VSYNC_CYCLES    = 1764,
  parameter int BURST_START     = 150,
  parameter int LINES_PER_FRAME = 262,
  parameter int VSYNC_LINES     = 3,
  parameter int ACTIVE_FIRST    = 40,
  parameter int ACTIVE_LINES    = 200,
  parameter int PIX_LOG2        = 8,
  parameter int WORD_LOG2       = 5,
  parameter int DIV_LOG2        = 2,
  localparam int WORD_BITS      = 1 << WORD_LOG2,
  localparam int ADDR_W         = $clog2(ACTIVE_LINES) + PIX_LOG2 - WORD_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 rdEn,
  output logic [ADDR_W-1:0]    rdAddr,
  input  logic [WORD_BITS-1:0] rdData,
  output logic                 syncN,
  output logic                 videoOut,
  output logic                 frameStart
);

  pixStrobe_t strobe;

  vid_line_ctrl #(
    .LINE_CYCLES    (LINE_CYCLES),
    .HSYNC_CYCLES   (HSYNC_CYCLES),
    .VSYNC_CYCLES   (VSYNC_CYCLES),
    .BURST_START    (BURST_START),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .VSYNC_LINES    (VSYNC_LINES),
    .ACTIVE_FIRST   (ACTIVE_FIRST),
    .ACTIVE_LINES   (ACTIVE_LINES),
    .PIX_LOG2       (PIX_LOG2),
    .WORD_LOG2      (WORD_LOG2),
    .DIV_LOG2       (DIV_LOG2)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .syncN     (syncN),
    .frameStart(frameStart)
  );

  vid_pixel_path #(
    .WORD_LOG2(WORD_LOG2)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .rdData  (rdData),
    .videoOut(videoOut)
  );

  assign rdEn = strobe.fetch;

endmodule

// File: tb/vid_timing_gen_bench.sv
`timescale 1ns/1ps
module vid_timing_gen_bench;

  localparam int L     = 48;
  localparam int HS    = 4;
  localparam int VS    = 40;
  localparam int BS    = 10;
  localparam int N     = 20;
  localparam int VL    = 3;
  localparam int AF    = 6;
  localparam int AL    = 10;
  localparam int PL    = 4;
  localparam int WL    = 3;
  localparam int DL    = 1;
  localparam int WB    = 1 << WL;
  localparam int NPIX  = 1 << PL;
  localparam int PD    = 1 << DL;
  localparam int WORDS = NPIX / WB;
  localparam int WC    = WB * PD;
  localparam int ADDR_W = $clog2(AL) + PL - WL;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rdEn;
  logic [ADDR_W-1:0] rdAddr;
  logic [WB-1:0]     rdData = '0;
  logic              syncN;
  logic              videoOut;
  logic              frameStart;

  vid_timing_gen #(
    .LINE_CYCLES(L), .HSYNC_CYCLES(HS), .VSYNC_CYCLES(VS), .BURST_START(BS),
    .LINES_PER_FRAME(N), .VSYNC_LINES(VL), .ACTIVE_FIRST(AF), .ACTIVE_LINES(AL),
    .PIX_LOG2(PL), .WORD_LOG2(WL), .DIV_LOG2(DL)
  ) u_vid_timing_gen (
    .clk(clk), .rst(rst), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .syncN(syncN), .videoOut(videoOut), .frameStart(frameStart)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int curFrame = 0;
  int m = 0;
  int lastFall = -1;
  logic prevSync = 1'b1;
  bit finished = 1'b0;

  function automatic logic [WB-1:0] pat(input int sel, input int addr);
    case (sel % 3)
      0:       return WB'(addr * 91) ^ 8'hA6;
      1:       return (addr % 2 == 0) ? 8'hFF : 8'h00;
      default: return 8'hAA ^ WB'(addr);
    endcase
  endfunction

  function automatic bit activeLine(input int ln);
    return (ln >= AF) && (ln < AF + AL);
  endfunction

  // Frame buffer model: one cycle of read latency.
  initial forever begin
    @(posedge clk);
    if (rdEn) rdData <= pat(curFrame, int'(rdAddr));
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (m=%0d)", tag, what, act, exp, m);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic resetPhase(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1", "syncN in reset", int'(syncN), 1);
      chk("R1", "videoOut in reset", int'(videoOut), 0);
      chk("R1", "frameStart in reset", int'(frameStart), 0);
      chk("R1", "rdEn in reset", int'(rdEn), 0);
    end
    rst = 1'b0;
    m = 0;
    lastFall = -1;
    prevSync = 1'b1;
    curFrame = 0;
  endtask

  task automatic runCycles(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      int t, c, ln, fr, expSync, expVid, expRd, pix;
      logic [WB-1:0] w;
      @(posedge clk);
      m++;
      @(negedge clk);
      t  = m - 1;
      c  = t % L;
      ln = (t / L) % N;
      fr = t / (L * N);
      curFrame = fr;

      // Sync pulse width per line kind
      expSync = (c < ((ln < VL) ? VS : HS)) ? 0 : 1;
      if (ln < VL) chk("R4", "vertical syncN", int'(syncN), expSync);
      else         chk("R3", "horizontal syncN", int'(syncN), expSync);

      // Line period from sync falling edges
      if (prevSync && !syncN) begin
        if (lastFall >= 0) chk("R2", "cycles between sync edges", m - lastFall, L);
        lastFall = m;
      end
      prevSync = syncN;

      // Frame marker
      chk("R5", "frameStart", int'(frameStart), (c == 0 && ln == 0) ? 1 : 0);

      // Video content
      if (activeLine(ln) && c >= BS && c < BS + NPIX * PD) begin
        pix = (c - BS) / PD;
        w = pat(fr, (ln - AF) * WORDS + pix / WB);
        expVid = int'(w[WB - 1 - pix % WB]);
        chk("R6 R7", "pixel in window", int'(videoOut), expVid);
      end else begin
        chk("R8", "dark outside window", int'(videoOut), 0);
      end

      // Read requests
      expRd = (activeLine(ln) && (c - (BS - 3)) >= 0 && (c - (BS - 3)) % WC == 0
               && (c - (BS - 3)) / WC < WORDS) ? 1 : 0;
      chk("R9", "rdEn", int'(rdEn), expRd);
      if (expRd == 1 && rdEn)
        chk("R9", "rdAddr", int'(rdAddr), (ln - AF) * WORDS + (c - (BS - 3)) / WC);
    end
  endtask

  initial begin
    resetPhase(4);
    runCycles(3 * N * L);
    runCycles(500);
    resetPhase(5);
    runCycles(N * L + 20);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(50000 * 5.0);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

endmodule